// File: doc/BRIEF.md
# Modulo Circular Address Generator

This block keeps the running source and destination addresses of one DMA channel. Each address is held in its own register. Software can write the register directly. Otherwise it advances once per completed transfer by the unit size of that side. Each side has an increment enable, a unit-size code and a 4-bit modulo code, and none of these settings is shared with the other side.

The modulo code picks a power-of-two window. With code zero the address counts up linearly over the whole address space. With a non-zero code the unit size is first added to the current address. Only the bits inside the window then take the result, and every bit above the window keeps its old value. The pointer therefore runs round a circular buffer whose base is aligned to the window size.

There is no sequencing beyond this. In every cycle each lane is in one of three conditions: *load* (a software write, which wins), *advance* (a completed-transfer strobe) or *hold* (neither). The registered address appears on the output in the cycle after the edge that captured it.

Top module: `modaddr_pair`

## Requirements
- R1: While reset is asserted, both address outputs read zero.
- R2: A load strobe on a side puts its load value on that side's address output after the next clock edge. This takes priority over a transfer strobe in the same cycle.
- R3: In a cycle with neither a load strobe nor a transfer strobe, both address outputs keep their values.
- R4: On a transfer strobe, a side whose increment enable is low keeps its address unchanged, whatever its unit or modulo code.
- R5: With modulo code 0, an advance adds the unit step to the address modulo 2^AW (linear counting with natural roll-over).
- R6: With modulo code n from 1 to 15, the window is 2^(n+3) bytes. The new address is (old & ~mask) | ((old + step) & mask), where mask = window − 1. The bits above the window never change on an advance.
- R7: The unit code maps to a step as follows: 0 gives 4 bytes, 1 gives 1 byte, 2 gives 2 bytes, and 3 gives 0 bytes, which holds the address.
- R8: Source and destination use their own increment, unit and modulo settings, and an advance of one side never depends on the settings of the other.
- R9: Code 15 selects a 256 KB window. For example, 0x1237FFFC with a 4-byte step advances to 0x12340000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_done | input | 1 | Completed-transfer strobe, advances both sides |
| src_load | input | 1 | Software write strobe, source address |
| src_load_val | input | AW | Value written to source address |
| src_inc | input | 1 | Source increment enable |
| src_unit | input | 2 | Source unit-size code |
| src_mod | input | 4 | Source modulo code |
| dst_load | input | 1 | Software write strobe, destination address |
| dst_load_val | input | AW | Value written to destination address |
| dst_inc | input | 1 | Destination increment enable |
| dst_unit | input | 2 | Destination unit-size code |
| dst_mod | input | 4 | Destination modulo code |
| src_addr | output | AW | Registered source address |
| dst_addr | output | AW | Registered destination address |

## Verification
A load, an advance or a hold decided in one cycle reaches both address outputs exactly one clock edge later, because a single register separates stimulus from result. The driver applies each stimulus at a falling edge and queues the pair of expected addresses. The monitor takes the item out three nanoseconds after the following rising edge. Every comparison therefore falls on the first stable window after the capturing edge, and never lands on an edge.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

    typedef enum logic [1:0] {
        UNIT_WORD = 2'd0,
        UNIT_BYTE = 2'd1,
        UNIT_HALF = 2'd2,
        UNIT_NONE = 2'd3
    } unit_e;

    localparam int MOD_W          = 4;
    localparam int WIN_BASE_SHIFT = 3;
    localparam int STEP_W         = 3;

    // Lane condition for one cycle
    typedef enum logic [1:0] {
        LANE_HOLD    = 2'd0,
        LANE_LOAD    = 2'd1,
        LANE_ADVANCE = 2'd2
    } lane_e;

    function automatic logic [STEP_W-1:0] unit_step(input logic [1:0] code);
        unit_e u;
        u = unit_e'(code);
        unique case (u)
            UNIT_WORD: return 3'd4;
            UNIT_BYTE: return 3'd1;
            UNIT_HALF: return 3'd2;
            UNIT_NONE: return 3'd0;
            default:   return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/modaddr_mask_gen.sv
module modaddr_mask_gen #(
    parameter int AW    = 32,
    parameter int MOD_W = modaddr_pkg::MOD_W
) (
    input  logic [MOD_W-1:0] mod_code,
    output logic [AW-1:0]    win_mask
);
    localparam int NCODE = 1 << MOD_W;

    logic [AW-1:0] cand [NCODE];

    // Code 0: the whole address is the window, so counting is linear
    assign cand[0] = '1;

    for (genvar g = 1; g < NCODE; g++) begin : g_cand
        localparam int WB = g + modaddr_pkg::WIN_BASE_SHIFT;
        if (WB >= AW) begin : g_full
            assign cand[g] = '1;
        end else begin : g_part
            assign cand[g] = {{(AW-WB){1'b0}}, {WB{1'b1}}};
        end
    end

    assign win_mask = cand[mod_code];
endmodule

// File: rtl/modaddr_next.sv
module modaddr_next #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic          inc,
    input  logic [1:0]    unit,
    input  logic [AW-1:0] win_mask,
    output logic [AW-1:0] nxt
);
    import modaddr_pkg::*;

    logic [STEP_W-1:0] step;
    logic [AW-1:0]     sum;

    always_comb begin
        step = unit_step(unit);
        sum  = cur + AW'(step);
        if (inc) nxt = (cur & ~win_mask) | (sum & win_mask);
        else     nxt = cur;
    end
endmodule

// File: rtl/modaddr_chan.sv
module modaddr_chan #(
    parameter int AW    = 32,
    parameter int MOD_W = modaddr_pkg::MOD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    load_val,
    input  logic             advance,
    input  logic             inc,
    input  logic [1:0]       unit,
    input  logic [MOD_W-1:0] mod_code,
    output logic [AW-1:0]    addr
);
    import modaddr_pkg::*;

    logic [AW-1:0] win_mask;
    logic [AW-1:0] nxt;
    lane_e         cond;

    modaddr_mask_gen #(.AW(AW), .MOD_W(MOD_W)) u_mask (
        .mod_code (mod_code),
        .win_mask (win_mask)
    );

    modaddr_next #(.AW(AW)) u_next (
        .cur      (addr),
        .inc      (inc),
        .unit     (unit),
        .win_mask (win_mask),
        .nxt      (nxt)
    );

    always_comb begin
        if (load)         cond = LANE_LOAD;
        else if (advance) cond = LANE_ADVANCE;
        else              cond = LANE_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else begin
            unique case (cond)
                LANE_LOAD:    addr <= load_val;
                LANE_ADVANCE: addr <= nxt;
                default:      addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/modaddr_pair.sv
module modaddr_pair #(
    parameter int AW    = 32,
    parameter int MOD_W = modaddr_pkg::MOD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_done,
    input  logic             src_load,
    input  logic [AW-1:0]    src_load_val,
    input  logic             src_inc,
    input  logic [1:0]       src_unit,
    input  logic [MOD_W-1:0] src_mod,
    input  logic             dst_load,
    input  logic [AW-1:0]    dst_load_val,
    input  logic             dst_inc,
    input  logic [1:0]       dst_unit,
    input  logic [MOD_W-1:0] dst_mod,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr
);
    localparam int NLANE = 2;

    logic             l_load [NLANE];
    logic [AW-1:0]    l_val  [NLANE];
    logic             l_inc  [NLANE];
    logic [1:0]       l_unit [NLANE];
    logic [MOD_W-1:0] l_mod  [NLANE];
    logic [AW-1:0]    l_addr [NLANE];

    assign l_load[0] = src_load;  assign l_load[1] = dst_load;
    assign l_val[0]  = src_load_val; assign l_val[1] = dst_load_val;
    assign l_inc[0]  = src_inc;   assign l_inc[1]  = dst_inc;
    assign l_unit[0] = src_unit;  assign l_unit[1] = dst_unit;
    assign l_mod[0]  = src_mod;   assign l_mod[1]  = dst_mod;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        modaddr_chan #(.AW(AW), .MOD_W(MOD_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (l_load[i]),
            .load_val (l_val[i]),
            .advance  (xfer_done),
            .inc      (l_inc[i]),
            .unit     (l_unit[i]),
            .mod_code (l_mod[i]),
            .addr     (l_addr[i])
        );
    end

    assign src_addr = l_addr[0];
    assign dst_addr = l_addr[1];
endmodule

// File: rtl/modaddr_pair_chk.sv
module modaddr_pair_chk #(
    parameter int AW    = 32,
    parameter int MOD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_done,
    input logic             src_load,
    input logic [AW-1:0]    src_load_val,
    input logic             src_inc,
    input logic [1:0]       src_unit,
    input logic [MOD_W-1:0] src_mod,
    input logic             dst_load,
    input logic [AW-1:0]    dst_load_val,
    input logic             dst_inc,
    input logic [1:0]       dst_unit,
    input logic [MOD_W-1:0] dst_mod,
    input logic [AW-1:0]    src_addr,
    input logic [AW-1:0]    dst_addr
);
    function automatic logic [AW-1:0] hi_keep(input logic [MOD_W-1:0] c);
        logic [AW-1:0] one;
        one = {{(AW-1){1'b0}}, 1'b1};
        if (c == '0) return '0;
        else return ~((one << (int'(c) + 3)) - one);
    endfunction

    logic [AW-1:0] s_hi, d_hi;
    always_comb begin
        s_hi = hi_keep(src_mod);
        d_hi = hi_keep(dst_mod);
    end

    // R1
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (src_addr == '0 && dst_addr == '0));

    p_src_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_load |=> src_addr == $past(src_load_val));
    p_dst_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dst_load |=> dst_addr == $past(dst_load_val));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done && !src_load && !dst_load) |=> ($stable(src_addr) && $stable(dst_addr)));

    p_src_noinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !src_load && !src_inc) |=> $stable(src_addr));
    p_dst_noinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !dst_load && !dst_inc) |=> $stable(dst_addr));

    p_src_byte_lin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !src_load && src_inc && src_unit == 2'd1 && src_mod == '0)
        |=> src_addr == $past(src_addr) + 1'b1);

    p_src_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !src_load && src_inc && src_mod != '0)
        |=> (src_addr & $past(s_hi)) == ($past(src_addr) & $past(s_hi)));
    p_dst_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !dst_load && dst_inc && dst_mod != '0)
        |=> (dst_addr & $past(d_hi)) == ($past(dst_addr) & $past(d_hi)));

    p_src_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !src_load && src_unit == 2'd3) |=> $stable(src_addr));
endmodule

bind modaddr_pair modaddr_pair_chk #(.AW(AW), .MOD_W(MOD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done),
    .src_load(src_load), .src_load_val(src_load_val), .src_inc(src_inc),
    .src_unit(src_unit), .src_mod(src_mod),
    .dst_load(dst_load), .dst_load_val(dst_load_val), .dst_inc(dst_inc),
    .dst_unit(dst_unit), .dst_mod(dst_mod),
    .src_addr(src_addr), .dst_addr(dst_addr)
);

// File: tb/sim_modaddr_pair.sv
`timescale 1ns/1ps
module sim_modaddr_pair;
    localparam int AW = 32;

    typedef struct {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_done = 1'b0;
    logic          src_load = 1'b0, dst_load = 1'b0;
    logic [AW-1:0] src_load_val = '0, dst_load_val = '0;
    logic          src_inc = 1'b0, dst_inc = 1'b0;
    logic [1:0]    src_unit = '0, dst_unit = '0;
    logic [3:0]    src_mod = '0, dst_mod = '0;
    logic [AW-1:0] src_addr, dst_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    exp_t sb[$];
    logic [AW-1:0] m_src = '0, m_dst = '0;

    always #5 clk = ~clk;

    modaddr_pair #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done),
        .src_load(src_load), .src_load_val(src_load_val), .src_inc(src_inc),
        .src_unit(src_unit), .src_mod(src_mod),
        .dst_load(dst_load), .dst_load_val(dst_load_val), .dst_inc(dst_inc),
        .dst_unit(dst_unit), .dst_mod(dst_mod),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a, input logic inc,
                                               input logic [1:0] unit, input logic [3:0] m);
        logic [AW-1:0] st, win, off;
        case (unit)
            2'd0: st = 4;
            2'd1: st = 1;
            2'd2: st = 2;
            default: st = 0;
        endcase
        if (!inc || st == 0) return a;
        if (m == 0) return a + st;
        win = 32'd1 << (int'(m) + 3);
        off = a % win;
        return (a - off) + ((off + st) % win);
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: one stimulus per cycle, expected result queued
    task automatic step(input string req, input logic xd,
                        input logic sl, input logic [AW-1:0] sv,
                        input logic si, input logic [1:0] su, input logic [3:0] sm,
                        input logic dl, input logic [AW-1:0] dv,
                        input logic di, input logic [1:0] du, input logic [3:0] dm);
        exp_t e;
        @(negedge clk);
        xfer_done = xd;
        src_load = sl; src_load_val = sv; src_inc = si; src_unit = su; src_mod = sm;
        dst_load = dl; dst_load_val = dv; dst_inc = di; dst_unit = du; dst_mod = dm;
        if (sl) m_src = sv; else if (xd) m_src = ref_next(m_src, si, su, sm);
        if (dl) m_dst = dv; else if (xd) m_dst = ref_next(m_dst, di, du, dm);
        e.src = m_src; e.dst = m_dst; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: 3 ns after each rising edge
    always @(posedge clk) begin
        #3;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.req, "src", src_addr, e.src);
            cmp(e.req, "dst", dst_addr, e.dst);
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1", "src", src_addr, '0);
        cmp("R1", "dst", dst_addr, '0);
        rst_n = 1'b1;
        // R2 loads
        step("R2", 0, 1, 32'h1000_0000, 0, 0, 0, 1, 32'h2000_00FC, 0, 0, 0);
        // R5 linear word steps on source, R6 16 B wrap on destination, R8 differing settings
        step("R5", 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        step("R8", 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        // R3 idle
        step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        // R7 unit codes
        step("R7", 1, 0, 0, 1, 1, 0, 0, 0, 1, 2, 2);
        step("R7", 1, 0, 0, 1, 2, 0, 0, 0, 1, 3, 2);
        step("R7", 1, 0, 0, 1, 3, 0, 0, 0, 1, 1, 2);
        // R4 increment off with modulo set
        step("R4", 1, 0, 0, 0, 0, 5, 0, 0, 0, 1, 1);
        // R6 byte wrap in 32 B window
        step("R6", 0, 1, 32'hABCD_001F, 0, 0, 0, 1, 32'h0000_0FFE, 0, 0, 0);
        step("R6", 1, 0, 0, 1, 1, 2, 0, 0, 1, 2, 6);
        step("R6", 1, 0, 0, 1, 1, 2, 0, 0, 1, 0, 1);
        // R9 code 15 window
        step("R9", 0, 1, 32'h1237_FFFC, 0, 0, 0, 1, 32'h5555_0000, 0, 0, 0);
        step("R9", 1, 0, 0, 1, 0, 15, 0, 0, 1, 0, 15);
        // R5 roll-over at the top of the address space
        step("R5", 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R2 load beats a transfer strobe in the same cycle
        step("R2", 1, 1, 32'h0000_4440, 1, 0, 0, 1, 32'h0000_8880, 1, 0, 3);
        step("R8", 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 3);
        step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule